// File: doc/BRIEF.md
# FIFO Retransmit Controller

A single-clock synchronous FIFO, 36 bits wide by default. It can replay its stored contents from the beginning. Writes go to the next free location. Reads pass the oldest unread word into a registered data output. An active-low retransmit request, sampled on a rising clock edge, moves the read position back to address 0, where the first word after master reset was stored. The write position and the stored words are left as they are.

The replay latency is chosen once, during master reset, from a select input.

- **Zero-latency mode:** the word at address 0 appears on the output register on the same edge that accepts the request. The next read returns the word at address 1.
- **Normal mode:** the output register keeps its value on the request edge. The word at address 0 comes out on the next read.

After a retransmit, the occupancy is rebuilt from the number of words written since reset, capped at the depth. A drained FIFO therefore becomes readable again.

The block assumes that a replay happens before the writer wraps past address 0. Words written after a wrap overwrite the oldest replay data.

Top module: `rtx_fifo`

## Requirements
- R1: While master reset (`rst_n` low, sampled synchronously) is held, and on the first cycle after it, `empty_o` is 1, `full_o` is 0 and `rd_data_o` is all zeros.
- R2: A write (`wr_en_i` high) is accepted only while `full_o` is 0. `full_o` rises once DEPTH words are held. A write while full stores nothing: after draining, only the first DEPTH words come out.
- R3: A read (`rd_en_i` high) while `empty_o` is 0 loads the oldest unread word into `rd_data_o` on that edge, in write order. A read while empty leaves `rd_data_o` unchanged.
- R4: The latency mode is taken from `lat_sel_i` during master reset (0 = zero latency, 1 = normal) and is held until the next reset, whatever `lat_sel_i` does afterwards.
- R5: In zero-latency mode, an accepted request (`rtx_n_i` low at a rising edge) loads the word at address 0 into `rd_data_o` on that same edge. The next read returns the word at address 1.
- R6: In normal mode, an accepted request leaves `rd_data_o` unchanged on that edge. The next read returns the word at address 0.
- R7: After an accepted request, the occupancy equals the number of words written since reset, saturated at DEPTH, minus one in zero-latency mode. Retransmitting a drained FIFO makes it readable again. After DEPTH writes, it makes `full_o` high.
- R8: When a request and a read arrive on the same edge, the request wins. The read does not move the pointer, so the following read returns the word the mode's replay order calls for.
- R9: A request is ignored when no word has been written since master reset: `empty_o` stays 1 and `rd_data_o` stays unchanged.
- R10: A request does not move the write position. A word written after a replay is read out after the replayed words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Master reset, active low, synchronous |
| lat_sel_i | input | 1 | Replay latency select, sampled during reset: 0 zero latency, 1 normal |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read enable |
| rtx_n_i | input | 1 | Retransmit request, active low |
| rd_data_o | output | DATA_W | Registered read data |
| empty_o | output | 1 | No unread word held |
| full_o | output | 1 | DEPTH unread words held |

## Verification
A table of vectors in normal mode interleaves writes, partial reads and replays. This shows whether the output holds on the request edge and whether the pointer returns to address 0 rather than staying where it was. The table also includes a replay together with a read, a replay after a full drain and a write right after a replay. Together these separate request priority, occupancy rebuild and write-pointer preservation.

Directed runs in zero-latency mode check that the first word appears on the request edge. They also check that the following read moves to address 1, and that the mode latched at reset survives a later change of the select pin. Further runs cover a replay with nothing ever written, a write into a full FIFO, and a replay after DEPTH writes, which must report full.

// File: rtl/rtx_fifo_pkg.sv
// Package for the retransmit FIFO: the replay latency encoding and the per-edge
// operation bundle passed from the controller to the storage and output stages.
package rtx_fifo_pkg;

    // Replay latency; the values match the select pin level during reset.
    typedef enum logic {
        LAT_ZERO   = 1'b0,
        LAT_NORMAL = 1'b1
    } rtx_lat_e;

    // Operations accepted on the current edge.
    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic rtx_go;
    } fifo_op_t;

endpackage

// File: rtl/rtx_fifo_store.sv
// Storage array of the retransmit FIFO.
// Does: writes one word per accepted write; gives the word at the read address
// and the word at address 0 combinationally.
// Assumes: addresses are always below DEPTH (the controller wraps them).
module rtx_fifo_store #(
    parameter  int DATA_W = 36,
    parameter  int DEPTH  = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_go_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_word_o,
    output logic [DATA_W-1:0] first_word_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge clk) begin
        if (wr_go_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Present the addressed word and the replay start word.
    always_comb begin
        rd_word_o    = mem[rd_addr_i];
        first_word_o = mem[0];
    end

endmodule

// File: rtl/rtx_fifo_ctrl.sv
// Pointer, occupancy and mode controller of the retransmit FIFO.
// Does: decides which operations are accepted on each edge, keeps the write and
// read pointers, the occupancy and the saturating count of words written since
// reset, and latches the replay latency mode during master reset.
// Assumes: synchronous active-low reset; a retransmit has priority over a read.
module rtx_fifo_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_sel_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic          rtx_n_i,
    output fifo_op_t      op_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          zero_lat_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [CW-1:0] count_q;
    logic [CW-1:0] fill_q;
    logic [CW-1:0] fill_nxt;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    rtx_lat_e      mode_q;
    fifo_op_t      op;

    // Advance an address by one with wrap at the last location.
    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return (a == LAST_ADDR) ? '0 : a + 1'b1;
    endfunction

    // Decide the accepted operations and the next written-word count.
    always_comb begin
        op.wr_go  = wr_en_i && (count_q != FULL_CNT);
        op.rtx_go = !rtx_n_i && (fill_q != '0);
        op.rd_go  = rd_en_i && (count_q != '0) && !op.rtx_go;
        fill_nxt  = (op.wr_go && (fill_q != FULL_CNT)) ? fill_q + 1'b1 : fill_q;
    end

    // Latch the replay latency while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rtx_lat_e'(lat_sel_i);
        end
    end

    // Advance the write pointer and the written-word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (op.wr_go) begin
                wptr_q <= next_addr(wptr_q);
            end
            fill_q <= fill_nxt;
        end
    end

    // Move the read pointer and occupancy on reads and replays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            count_q <= '0;
        end else if (op.rtx_go) begin
            if (mode_q == LAT_ZERO) begin
                rptr_q  <= next_addr('0);
                count_q <= fill_nxt - 1'b1;
            end else begin
                rptr_q  <= '0;
                count_q <= fill_nxt;
            end
        end else begin
            if (op.rd_go) begin
                rptr_q <= next_addr(rptr_q);
            end
            count_q <= count_q + CW'(op.wr_go) - CW'(op.rd_go);
        end
    end

    // Drive the controller outputs.
    always_comb begin
        op_o       = op;
        wr_addr_o  = wptr_q;
        rd_addr_o  = rptr_q;
        zero_lat_o = (mode_q == LAT_ZERO);
        empty_o    = (count_q == '0);
        full_o     = (count_q == FULL_CNT);
    end

endmodule

// File: rtl/rtx_fifo_outreg.sv
// Output data register of the retransmit FIFO.
// Does: loads the replay start word on a zero-latency replay, or the addressed
// word on a read, and otherwise holds its value.
// Assumes: the two load strobes are never both high (the controller gives the
// replay priority).
module rtx_fifo_outreg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first_i,
    input  logic              load_read_i,
    input  logic [DATA_W-1:0] first_word_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [DATA_W-1:0] rd_data_o
);

    // Register the selected word, cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (load_first_i) begin
            rd_data_o <= first_word_i;
        end else if (load_read_i) begin
            rd_data_o <= rd_word_i;
        end
    end

endmodule

// File: rtl/rtx_fifo.sv
// Top of the retransmit FIFO.
// Does: ties the controller, storage and output register together; a low on
// rtx_n_i replays the contents from address 0 with the latency chosen at reset.
// Assumes: one clock for both sides; a replay happens before writes wrap past
// address 0.
module rtx_fifo
    import rtx_fifo_pkg::*;
#(
    parameter  int DATA_W = 36,
    parameter  int DEPTH  = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              rtx_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              full_o
);

    fifo_op_t          op;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic              zero_lat;
    logic              wr_go;
    logic              rd_go;
    logic              rtx_go;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] first_word;

    // Split the operation bundle into named strobes.
    always_comb begin
        wr_go  = op.wr_go;
        rd_go  = op.rd_go;
        rtx_go = op.rtx_go;
    end

    rtx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_sel_i  (lat_sel_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .rtx_n_i    (rtx_n_i),
        .op_o       (op),
        .wr_addr_o  (wr_addr),
        .rd_addr_o  (rd_addr),
        .zero_lat_o (zero_lat),
        .empty_o    (empty_o),
        .full_o     (full_o)
    );

    rtx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .wr_go_i      (wr_go),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr),
        .rd_word_o    (rd_word),
        .first_word_o (first_word)
    );

    rtx_fifo_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_first_i (rtx_go && zero_lat),
        .load_read_i  (rd_go),
        .first_word_i (first_word),
        .rd_word_i    (rd_word),
        .rd_data_o    (rd_data_o)
    );

endmodule

// File: rtl/rtx_fifo_chk.sv
// Assertion checker for the retransmit FIFO, bound to every rtx_fifo instance.
// Does: checks flag consistency, full and empty blocking, mode retention and
// the output register behaviour on accepted replays.
// Assumes: rst_n is low from time zero until the first clock edges.
module rtx_fifo_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              rtx_n_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              empty_o,
    input logic              full_o,
    input logic              zero_lat,
    input logic              rtx_go,
    input logic [DATA_W-1:0] first_word
);

    // R1: empty and full never together
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    // R2: a write alone into a full FIFO keeps it full
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_en_i && !rd_en_i && rtx_n_i) |=> full_o);

    // R3: a read on an empty FIFO leaves the output alone
    a_r3_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && empty_o && rtx_n_i) |=> $stable(rd_data_o));

    // R4: latency mode does not change outside reset
    a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(zero_lat));

    // R5: zero-latency replay loads the start word on the request edge
    a_r5_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rtx_go && zero_lat) |=> (rd_data_o == $past(first_word)));

    // R6: normal replay holds the output on the request edge
    a_r6_normal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rtx_go && !zero_lat) |=> $stable(rd_data_o));

    // R7: normal replay leaves data to read
    a_r7_replay_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rtx_go && !zero_lat) |=> !empty_o);

endmodule

bind rtx_fifo rtx_fifo_chk #(.DATA_W(DATA_W)) u_rtx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .rtx_n_i    (rtx_n_i),
    .rd_data_o  (rd_data_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .zero_lat   (zero_lat),
    .rtx_go     (rtx_go),
    .first_word (first_word)
);

// File: tb/rtx_fifo_bench.sv
// Self-checking bench for rtx_fifo: a vector table in normal mode, then directed
// runs for reset, zero latency, ignored replays and the full boundary.
module rtx_fifo_bench;

    localparam int DATA_W = 36;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lat_sel = 1'b1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              rtx_n = 1'b1;
    logic [DATA_W-1:0] rd_data;
    logic              empty;
    logic              full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rtx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rtx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_sel_i (lat_sel),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rtx_n_i   (rtx_n),
        .rd_data_o (rd_data),
        .empty_o   (empty),
        .full_o    (full)
    );

    // Vector: write, read, replay request, write id, expected output id, flags.
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       rtx;
        logic [7:0] wid;
        logic [7:0] eid;
        logic       ee;
        logic       ef;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'd1, 8'd0, 1'b0, 1'b0},  // R2 write
        '{1'b1, 1'b0, 1'b0, 8'd2, 8'd0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0, 1'b0},  // R3 order
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd2, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 8'd0, 8'd2, 1'b0, 1'b0},  // R6 hold on request
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0, 1'b0},  // R6 address 0 next
        '{1'b0, 1'b1, 1'b1, 8'd0, 8'd1, 1'b0, 1'b0},  // R8 replay beats read
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0, 1'b0},  // R8 pointer at 0
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd2, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd3, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd3, 1'b1, 1'b0},  // R3 read while empty
        '{1'b0, 1'b0, 1'b1, 8'd0, 8'd3, 1'b0, 1'b0},  // R7 drained replay
        '{1'b1, 1'b1, 1'b0, 8'd4, 8'd1, 1'b0, 1'b0},  // R10 write after replay
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd2, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd3, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'd0, 8'd4, 1'b1, 1'b0}   // R10 new word last
    };

    // Test word for an id; id 0 stands for the all-zero reset value.
    function automatic logic [DATA_W-1:0] mk(input logic [7:0] id);
        return (id == 8'd0) ? '0 : {4'h5, id, id, id, id};
    endfunction

    // Compare one value and report a failure.
    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, return at the next one.
    task automatic step(input logic wr, input logic [7:0] wid, input logic rd,
                        input logic rtx);
        wr_en   = wr;
        wr_data = mk(wid);
        rd_en   = rd;
        rtx_n   = ~rtx;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        rtx_n = 1'b1;
    endtask

    // Apply master reset with the given latency select.
    task automatic do_reset(input logic lat);
        @(negedge clk);
        rst_n   = 1'b0;
        lat_sel = lat;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Print the summary once and end.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state, normal mode
        do_reset(1'b1);
        chk("R1 empty", {35'd0, empty}, 36'd1);
        chk("R1 full", {35'd0, full}, 36'd0);
        chk("R1 data", rd_data, '0);

        // Table walk, normal latency
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].wid, TBL[i].rd, TBL[i].rtx);
            chk(TBL[i].rtx ? "R6/R8 data" : (TBL[i].rd ? "R3 data" : "R2 data"),
                rd_data, mk(TBL[i].eid));
            chk("R7 empty", {35'd0, empty}, {35'd0, TBL[i].ee});
            chk("R2 full", {35'd0, full}, {35'd0, TBL[i].ef});
        end

        // R9 replay with nothing written, normal then zero latency
        do_reset(1'b1);
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R9 empty normal", {35'd0, empty}, 36'd1);
        chk("R9 data normal", rd_data, '0);
        do_reset(1'b0);
        step(1'b0, 8'd0, 1'b1, 1'b1);
        chk("R9 empty zero", {35'd0, empty}, 36'd1);
        chk("R9 data zero", rd_data, '0);

        // Zero latency; select pin changed after reset must not matter (R4)
        do_reset(1'b0);
        lat_sel = 1'b1;
        step(1'b1, 8'd11, 1'b0, 1'b0);
        step(1'b1, 8'd12, 1'b0, 1'b0);
        step(1'b1, 8'd13, 1'b0, 1'b0);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R3 zero first read", rd_data, mk(8'd11));
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R5 same edge word0 (R4 mode kept)", rd_data, mk(8'd11));
        chk("R5 not empty", {35'd0, empty}, 36'd0);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R5 next is address 1", rd_data, mk(8'd12));
        step(1'b0, 8'd0, 1'b1, 1'b1);
        chk("R8 zero replay wins", rd_data, mk(8'd11));
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R8 pointer at 1", rd_data, mk(8'd12));
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R3 last word", rd_data, mk(8'd13));
        chk("R3 drained", {35'd0, empty}, 36'd1);
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R7 zero drained replay data", rd_data, mk(8'd11));
        chk("R7 zero drained replay empty", {35'd0, empty}, 36'd0);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R7 zero occupancy", rd_data, mk(8'd13));
        chk("R7 zero empty after", {35'd0, empty}, 36'd1);

        // Full boundary, normal latency
        do_reset(1'b1);
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 8'(20 + k), 1'b0, 1'b0);
        end
        chk("R2 full after DEPTH writes", {35'd0, full}, 36'd1);
        step(1'b1, 8'd99, 1'b0, 1'b0);
        chk("R2 full stays", {35'd0, full}, 36'd1);
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b0, 8'd0, 1'b1, 1'b0);
            chk("R2 drain order", rd_data, mk(8'(20 + k)));
        end
        chk("R2 extra write dropped", {35'd0, empty}, 36'd1);
        step(1'b0, 8'd0, 1'b0, 1'b1);
        chk("R7 saturated replay full", {35'd0, full}, 36'd1);
        step(1'b0, 8'd0, 1'b1, 1'b0);
        chk("R6 replay from start", rd_data, mk(8'd20));

        finish_run();
    end

endmodule